// File: doc/BRIEF.md
# Signed Multiply-Divide Unit with Full-Precision Math Register

This block performs signed 16-bit (parameter `W`) multiplication and division on two operands. Each operation writes a single-word destination and a set of result flags. It also writes a two-word math register that holds the full-precision result. For a multiply that is the double-width product. For a divide it is the remainder and the truncated quotient. The math register is never affected by the way the destination was clipped.

A multiply finishes in one registered cycle. A divide runs a restoring divider that resolves one quotient bit per clock. `busy` is high while the divider runs, and `done` pulses once when the result is ready. The destination of a divide is the quotient rounded to the nearest integer, with halves rounded away from zero. A result that does not fit the destination raises the overflow flag and a sticky trap bit. A divide by zero does the same. The mode input `wrap_en` chooses whether an oversized result saturates or keeps its low word. It is sampled when the operation starts, so a change applies to the very next operation.

Top module: `mdu_mathreg`

## Requirements
- R1: With `op`=0 (multiply) a `start` sampled while `busy` is low gives `done`=1 in the following cycle. At that point `mreg_lo` holds product bits W-1:0 and `mreg_hi` holds product bits 2W-1:W of the signed 2W-bit product.
- R2: With `op`=1 (divide) and a nonzero divisor, `busy` is high from the cycle after `start` until `done`. `done` rises W+1 cycles later than a multiply's would, so it is the (W+2)th cycle after the start cycle. `busy` is low while `done` is high, and `done` lasts one cycle.
- R3: After a divide with a nonzero divisor, `mreg_hi` holds the low W bits of the quotient truncated toward zero. `mreg_lo` holds the remainder, which carries the sign of the dividend. For -2^(W-1) / -1 the high word is 2^(W-1) as an unsigned pattern.
- R4: The destination of a divide is the quotient rounded to the nearest integer, with exact halves rounded away from zero.
- R5: When the signed result lies outside [-2^(W-1), 2^(W-1)-1], `ovf` is 1 and `trap` becomes 1. Otherwise `ovf` is 0.
- R6: With `wrap_en`=0 an oversized result saturates to 2^(W-1)-1 or -2^(W-1) by its sign. With `wrap_en`=1 the low W bits are kept. The math register is the same in both modes, and the mode is taken from the start cycle.
- R7: A divide by zero gives `done` in the following cycle with `ovf`=1 and `trap`=1. `dest` is 2^(W-1)-1 when the dividend is non-negative and -2^(W-1) when it is negative. Both math register words keep their previous values.
- R8: `trap` stays high until `trap_clr`, which clears it in the next cycle. A new overflow in the same cycle as `trap_clr` wins.
- R9: `zero` is 1 exactly when `dest` is 0, and `neg` equals bit W-1 of `dest`. `dest`, flags and math register hold their values between operations.
- R10: A `start` seen while `busy` is high is ignored. It neither alters the result of the running divide nor produces an extra `done`.
- R11: After reset every output is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin an operation |
| op | input | 1 | 0 multiply, 1 divide |
| opa | input | W | Multiplicand or dividend (signed) |
| opb | input | W | Multiplier or divisor (signed) |
| wrap_en | input | 1 | 1 keeps low word on overflow, 0 saturates |
| trap_clr | input | 1 | Clears the sticky trap bit |
| busy | output | 1 | Divide in progress |
| done | output | 1 | One-cycle completion pulse |
| dest | output | W | Destination word |
| ovf | output | 1 | Result did not fit the destination |
| zero | output | 1 | Destination is zero |
| neg | output | 1 | Destination is negative |
| trap | output | 1 | Sticky overflow / divide-by-zero bit |
| mreg_lo | output | W | Math register low word |
| mreg_hi | output | W | Math register high word |

## Verification
The bench aims at operand extremes: products of -32768 with itself and with -1, and the quotient -32768 / -1, which overflows only in the destination. A design that clipped the math register, or derived it from the destination, would show a saturated word there instead of the full result. Small divisors produce exact halves on both signs, so rounding toward zero, or away from zero in only one direction, gives a wrong destination. Divide by zero with both dividend signs, a mode flip right after start, and a start poked while the divider is busy catch a trap that is lost, a stale math register that gets overwritten, a mode sampled late, and a divide corrupted by a second request.

// File: rtl/mdu_pkg.sv
package mdu_pkg;
   typedef enum logic {
      OP_MUL = 1'b0,
      OP_DIV = 1'b1
   } mdu_op_e;
endpackage

// File: rtl/mdu_divcore.sv
// Restoring divider on unsigned magnitudes, one quotient bit per clock.
module mdu_divcore #(
   parameter int W = 16
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         load,
   input  logic [W-1:0] dvd,
   input  logic [W-1:0] dsr,
   output logic         run,
   output logic         fin,
   output logic [W-1:0] quo,
   output logic [W-1:0] rem,
   output logic [W-1:0] dsr_hold
);
   localparam int CW = $clog2(W + 1);

   logic [CW-1:0] cnt;
   logic [W-1:0]  rem_q, quo_q, dsr_q;
   logic [W:0]    rem_sh, rem_sub;
   logic          ge;

   assign rem_sh  = {rem_q, quo_q[W-1]};
   assign ge      = rem_sh >= {1'b0, dsr_q};
   assign rem_sub = ge ? (rem_sh - {1'b0, dsr_q}) : rem_sh;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt   <= '0;
         rem_q <= '0;
         quo_q <= '0;
         dsr_q <= '0;
         run   <= 1'b0;
         fin   <= 1'b0;
      end else begin
         fin <= 1'b0;
         if (load) begin
            rem_q <= '0;
            quo_q <= dvd;
            dsr_q <= dsr;
            cnt   <= CW'(W);
            run   <= 1'b1;
         end else if (run) begin
            rem_q <= rem_sub[W-1:0];
            quo_q <= {quo_q[W-2:0], ge};
            cnt   <= cnt - 1'b1;
            if (cnt == CW'(1)) begin
               run <= 1'b0;
               fin <= 1'b1;
            end
         end
      end
   end

   assign quo      = quo_q;
   assign rem      = rem_q;
   assign dsr_hold = dsr_q;
endmodule

// File: rtl/mdu_divfix.sv
// Applies signs to the divider magnitudes and forms the destination quotient.
module mdu_divfix #(
   parameter int W             = 16,
   parameter bit ROUND_NEAREST = 1'b1
) (
   input  logic [W-1:0]          qmag,
   input  logic [W-1:0]          rmag,
   input  logic [W-1:0]          dmag,
   input  logic                  qneg,
   input  logic                  rneg,
   output logic signed [2*W-1:0] qval,
   output logic [W-1:0]          mlo,
   output logic [W-1:0]          mhi
);
   logic [W:0]     qsel;
   logic [2*W-1:0] qext;

   generate
      if (ROUND_NEAREST) begin : g_round
         logic up;
         assign up   = {rmag, 1'b0} >= {1'b0, dmag};
         assign qsel = {1'b0, qmag} + (W+1)'(up);
      end else begin : g_trunc
         assign qsel = {1'b0, qmag};
      end
   endgenerate

   assign qext = {{(W-1){1'b0}}, qsel};
   assign qval = qneg ? $signed(~qext + 1'b1) : $signed(qext);
   assign mhi  = qneg ? (~qmag + 1'b1) : qmag;
   assign mlo  = rneg ? (~rmag + 1'b1) : rmag;
endmodule

// File: rtl/mdu_shape.sv
// Fits a double-width signed result into one word by saturation or wrap.
module mdu_shape #(
   parameter int W = 16
) (
   input  logic signed [2*W-1:0] value,
   input  logic                  wrap,
   output logic [W-1:0]          dest,
   output logic                  ovf
);
   localparam logic [W-1:0] SAT_MAX = {1'b0, {(W-1){1'b1}}};
   localparam logic [W-1:0] SAT_MIN = {1'b1, {(W-1){1'b0}}};

   logic [W:0] upper;
   assign upper = value[2*W-1:W-1];
   assign ovf   = !((&upper) || !(|upper));
   assign dest  = (!ovf || wrap) ? value[W-1:0]
                                 : (value[2*W-1] ? SAT_MIN : SAT_MAX);
endmodule

// File: rtl/mdu_mathreg.sv
module mdu_mathreg #(
   parameter int W             = 16,
   parameter bit ROUND_NEAREST = 1'b1
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         start,
   input  logic         op,
   input  logic [W-1:0] opa,
   input  logic [W-1:0] opb,
   input  logic         wrap_en,
   input  logic         trap_clr,
   output logic         busy,
   output logic         done,
   output logic [W-1:0] dest,
   output logic         ovf,
   output logic         zero,
   output logic         neg,
   output logic         trap,
   output logic [W-1:0] mreg_lo,
   output logic [W-1:0] mreg_hi
);
   import mdu_pkg::*;

   localparam logic [W-1:0] SAT_MAX = {1'b0, {(W-1){1'b1}}};
   localparam logic [W-1:0] SAT_MIN = {1'b1, {(W-1){1'b0}}};

   generate
      if (W < 4) begin : g_bad_width
         $error("mdu_mathreg: W must be at least 4");
      end
   endgenerate

   mdu_op_e op_e;
   logic    accept, div_go, div_zero;
   logic [W-1:0] a_mag, b_mag;
   logic signed [2*W-1:0] prod;

   assign op_e     = mdu_op_e'(op);
   assign accept   = start && !busy;
   assign div_zero = (opb == '0);
   assign div_go   = accept && (op_e == OP_DIV) && !div_zero;
   assign a_mag    = opa[W-1] ? (~opa + 1'b1) : opa;
   assign b_mag    = opb[W-1] ? (~opb + 1'b1) : opb;
   assign prod     = $signed({{W{opa[W-1]}}, opa}) * $signed({{W{opb[W-1]}}, opb});

   // divider
   logic         c_run, c_fin;
   logic [W-1:0] c_quo, c_rem, c_dsr;

   mdu_divcore #(.W(W)) u_core (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (div_go),
      .dvd      (a_mag),
      .dsr      (b_mag),
      .run      (c_run),
      .fin      (c_fin),
      .quo      (c_quo),
      .rem      (c_rem),
      .dsr_hold (c_dsr)
   );

   logic wrap_q, qneg_q, rneg_q;
   logic signed [2*W-1:0] div_val;
   logic [W-1:0] div_lo, div_hi;

   mdu_divfix #(.W(W), .ROUND_NEAREST(ROUND_NEAREST)) u_fix (
      .qmag (c_quo),
      .rmag (c_rem),
      .dmag (c_dsr),
      .qneg (qneg_q),
      .rneg (rneg_q),
      .qval (div_val),
      .mlo  (div_lo),
      .mhi  (div_hi)
   );

   // one shaper shared by both result paths
   logic signed [2*W-1:0] shp_val;
   logic         shp_wrap, shp_ovf;
   logic [W-1:0] shp_dest;

   assign shp_val  = busy ? div_val : prod;
   assign shp_wrap = busy ? wrap_q : wrap_en;

   mdu_shape #(.W(W)) u_shape (
      .value (shp_val),
      .wrap  (shp_wrap),
      .dest  (shp_dest),
      .ovf   (shp_ovf)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy    <= 1'b0;
         done    <= 1'b0;
         dest    <= '0;
         ovf     <= 1'b0;
         zero    <= 1'b0;
         neg     <= 1'b0;
         trap    <= 1'b0;
         mreg_lo <= '0;
         mreg_hi <= '0;
         wrap_q  <= 1'b0;
         qneg_q  <= 1'b0;
         rneg_q  <= 1'b0;
      end else begin
         done <= 1'b0;
         if (trap_clr) trap <= 1'b0;
         if (accept && op_e == OP_MUL) begin
            dest    <= shp_dest;
            ovf     <= shp_ovf;
            zero    <= (shp_dest == '0);
            neg     <= shp_dest[W-1];
            mreg_lo <= prod[W-1:0];
            mreg_hi <= prod[2*W-1:W];
            if (shp_ovf) trap <= 1'b1;
            done    <= 1'b1;
         end else if (accept && div_zero) begin
            dest <= opa[W-1] ? SAT_MIN : SAT_MAX;
            ovf  <= 1'b1;
            zero <= 1'b0;
            neg  <= opa[W-1];
            trap <= 1'b1;
            done <= 1'b1;
         end else if (div_go) begin
            busy   <= 1'b1;
            wrap_q <= wrap_en;
            qneg_q <= opa[W-1] ^ opb[W-1];
            rneg_q <= opa[W-1];
         end else if (busy && c_fin) begin
            dest    <= shp_dest;
            ovf     <= shp_ovf;
            zero    <= (shp_dest == '0);
            neg     <= shp_dest[W-1];
            mreg_lo <= div_lo;
            mreg_hi <= div_hi;
            if (shp_ovf) trap <= 1'b1;
            busy    <= 1'b0;
            done    <= 1'b1;
         end
      end
   end
endmodule

// File: rtl/mdu_mathreg_chk.sv
module mdu_mathreg_chk #(
   parameter int W = 16
) (
   input logic         clk,
   input logic         rst_n,
   input logic         start,
   input logic         op,
   input logic [W-1:0] opb,
   input logic         trap_clr,
   input logic         busy,
   input logic         done,
   input logic [W-1:0] dest,
   input logic         ovf,
   input logic         trap,
   input logic [W-1:0] mreg_lo
);
   logic last_mul;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) last_mul <= 1'b0;
      else if (start && !busy) last_mul <= !op;
   end

   assert_mul_one_cycle_R1: assert property (@(posedge clk) disable iff (!rst_n)
      (start && !busy && !op) |=> (done && !busy));

   assert_div_goes_busy_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (start && !busy && op && opb != '0) |=> (busy && !done));

   assert_done_not_busy_R2: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> !busy);

   assert_no_overflow_lost_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (done && ovf) |-> trap);

   assert_trap_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (trap && !trap_clr) |=> trap);

   assert_mul_low_word_R1: assert property (@(posedge clk) disable iff (!rst_n)
      (done && last_mul && !ovf) |-> (mreg_lo == dest));
endmodule

bind mdu_mathreg mdu_mathreg_chk #(.W(W)) u_chk (.*);

// File: tb/mdu_mathreg_bench.sv
module mdu_mathreg_bench;
   localparam int W = 16;
   localparam time CLK_PERIOD = 10ns;

   logic clk = 1'b0, rst_n = 1'b0;
   logic start = 1'b0, op = 1'b0, wrap_en = 1'b0, trap_clr = 1'b0;
   logic [W-1:0] opa = '0, opb = '0;
   logic busy, done, ovf, zero, neg, trap;
   logic [W-1:0] dest, mreg_lo, mreg_hi;

   int checks = 0, fails = 0;
   bit exp_trap = 1'b0;
   logic [W-1:0] exp_lo = '0, exp_hi = '0;

   always #(CLK_PERIOD/2) clk = ~clk;

   mdu_mathreg #(.W(W)) u_mdu_mathreg (
      .clk(clk), .rst_n(rst_n), .start(start), .op(op), .opa(opa), .opb(opb),
      .wrap_en(wrap_en), .trap_clr(trap_clr), .busy(busy), .done(done),
      .dest(dest), .ovf(ovf), .zero(zero), .neg(neg), .trap(trap),
      .mreg_lo(mreg_lo), .mreg_hi(mreg_hi)
   );

   task automatic chk(input string req, input longint act, input longint exp);
      checks++;
      if (act != exp) begin
         fails++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   function automatic logic [W-1:0] fit(input int v, input bit wrap, output bit o);
      o = (v > 32767) || (v < -32768);
      if (!o || wrap) return v[15:0];
      return (v < 0) ? 16'h8000 : 16'h7fff;
   endfunction

   task automatic run(input bit dop, input logic [W-1:0] a, input logic [W-1:0] b,
                      input bit wrap, input bit poke);
      int ai, bi, v, q, r, qm, rm, bm, lat, exp_lat;
      bit o, dz, early;
      logic [W-1:0] ed;
      ai = int'($signed(a));
      bi = int'($signed(b));
      dz = dop && (bi == 0);
      if (!dop) begin
         v = ai * bi;
         ed = fit(v, wrap, o);
         exp_lo = v[15:0];
         exp_hi = v[31:16];
      end else if (dz) begin
         o = 1'b1;
         ed = (ai < 0) ? 16'h8000 : 16'h7fff;
      end else begin
         q = ai / bi;
         r = ai % bi;
         exp_lo = r[15:0];
         exp_hi = q[15:0];
         qm = (q < 0) ? -q : q;
         rm = (r < 0) ? -r : r;
         bm = (bi < 0) ? -bi : bi;
         if (2 * rm >= bm) qm++;
         v = ((ai < 0) != (bi < 0)) ? -qm : qm;
         ed = fit(v, wrap, o);
      end
      if (o) exp_trap = 1'b1;
      exp_lat = (dop && !dz) ? W + 2 : 1;

      @(negedge clk);
      start = 1'b1; op = dop; opa = a; opb = b; wrap_en = wrap;
      @(negedge clk);
      start = 1'b0;
      wrap_en = ~wrap; // R6: mode after start must not matter
      lat = 1;
      early = 1'b0;
      if (exp_lat > 1) chk("R2 busy after start", busy, 1);
      if (poke) begin
         start = 1'b1; op = 1'b0; opa = 16'h1234; opb = 16'h0003;
      end
      while (!done && lat < 64) begin
         @(negedge clk);
         start = 1'b0;
         lat++;
         if (!done && !busy) early = 1'b1;
      end
      start = 1'b0;
      chk("R2 done latency", lat, exp_lat);
      chk("R2 busy held", early, 0);
      chk("R2 busy low at done", busy, 0);
      chk(dop ? (dz ? "R7 dest" : "R4 R6 dest") : "R1 R6 dest", dest, ed);
      chk(dz ? "R7 ovf" : "R5 ovf", ovf, o);
      chk("R5 R8 trap", trap, exp_trap);
      chk("R9 zero", zero, ed == 0);
      chk("R9 neg", neg, ed[15]);
      chk(dop ? (dz ? "R7 mreg_lo kept" : "R3 mreg_lo") : "R1 mreg_lo", mreg_lo, exp_lo);
      chk(dop ? (dz ? "R7 mreg_hi kept" : "R3 mreg_hi") : "R1 mreg_hi", mreg_hi, exp_hi);
      @(negedge clk);
      chk(poke ? "R10 no extra done" : "R2 done one cycle", done, 0);
      chk("R9 dest held", dest, ed);
      chk("R9 mreg held", mreg_hi, exp_hi);
      wrap_en = 1'b0;
   endtask

   task automatic clear_trap;
      @(negedge clk);
      trap_clr = 1'b1;
      @(negedge clk);
      trap_clr = 1'b0;
      exp_trap = 1'b0;
      chk("R8 trap cleared", trap, 0);
   endtask

   function automatic logic [W-1:0] pick();
      case ($urandom_range(0, 7))
         0: return 16'h8000;
         1: return 16'h7fff;
         2: return 16'hffff;
         3: return W'($urandom_range(0, 9));
         4: return -W'($urandom_range(1, 9));
         default: return W'($urandom);
      endcase
   endfunction

   initial begin : watchdog
      #(CLK_PERIOD * 150000);
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

   initial begin
      void'($urandom(32'h5eed_0101));
      #(CLK_PERIOD * 3);
      @(negedge clk);
      // R11 reset state
      chk("R11 busy", busy, 0);
      chk("R11 done", done, 0);
      chk("R11 dest", dest, 0);
      chk("R11 flags", {ovf, zero, neg, trap}, 0);
      chk("R11 mreg", {mreg_hi, mreg_lo}, 0);
      rst_n = 1'b1;

      // directed corners
      run(1'b0, 16'h8000, 16'h8000, 1'b0, 1'b0); // R1 R5 saturate, full product
      run(1'b0, 16'h8000, 16'h8000, 1'b1, 1'b0); // R6 wrap
      clear_trap();
      run(1'b0, 16'h8000, 16'hffff, 1'b0, 1'b0); // +32768 saturates
      clear_trap();
      run(1'b0, 16'h0100, 16'hff00, 1'b0, 1'b0); // exact -65536 overflow
      clear_trap();
      run(1'b0, 16'd181, 16'd181, 1'b0, 1'b0);   // fits, trap stays clear
      run(1'b1, 16'h8000, 16'hffff, 1'b0, 1'b0); // R3 mreg_hi 0x8000, R5
      run(1'b1, 16'h8000, 16'hffff, 1'b1, 1'b0);
      run(1'b1, 16'd7, 16'd2, 1'b0, 1'b0);       // R4 3.5 -> 4
      run(1'b1, -16'sd7, 16'd2, 1'b0, 1'b0);     // R4 -3.5 -> -4
      run(1'b1, 16'd5, -16'sd3, 1'b0, 1'b0);     // R4 -1.67 -> -2
      run(1'b1, 16'd1, 16'd3, 1'b0, 1'b0);       // R4 0.33 -> 0
      run(1'b1, 16'd100, 16'd0, 1'b0, 1'b0);     // R7 positive dividend
      run(1'b1, 16'hfff0, 16'd0, 1'b1, 1'b0);    // R7 negative dividend
      run(1'b1, 16'd0, 16'd0, 1'b0, 1'b0);       // R7 zero dividend
      // R8: overflow coinciding with a clear keeps the trap set
      @(negedge clk);
      trap_clr = 1'b1; start = 1'b1; op = 1'b1; opa = 16'd9; opb = 16'd0;
      @(negedge clk);
      trap_clr = 1'b0; start = 1'b0;
      chk("R8 set beats clear", trap, 1);
      clear_trap();
      run(1'b1, 16'h7fff, 16'd3, 1'b0, 1'b1);    // R10 poke during divide
      run(1'b1, 16'h8000, 16'd2, 1'b0, 1'b1);

      for (int i = 0; i < 300; i++) begin
         run(1'($urandom_range(0, 1)), pick(), pick(), 1'($urandom_range(0, 1)),
             ($urandom_range(0, 9) == 0));
         if ($urandom_range(0, 5) == 0) clear_trap();
      end

      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end
endmodule